// File: doc/BRIEF.md
# Serial Word Shifter with Selectable Output Edge

This block is the serial front end of a daisy-chainable slave on a 3-wire SPI or Microwire bus. While the active-low select is held low, it samples the serial data input on each rising serial-clock edge into a word-wide shift register, most significant bit first. When the select returns high after exactly one full word, it passes the captured word to a downstream command decoder with a one-cycle valid strobe.

The serial output always carries the top bit of the shift register. A mode input chooses whether that output is updated on falling or on rising serial-clock edges. In both modes a device further down a chain samples each bit exactly one word length after it entered the first device, so any number of devices can share one select and one clock. The command decoder owns the mode and must clear it to falling-edge mode on reset.

The serial lines may be asynchronous to the system clock. Each passes through a synchroniser, and edges are found in the system-clock domain, so the system clock must run at least eight times faster than the serial clock.

Top module: `spi_word_shifter`

## Requirements
- R1: While `cs_ni` is low, each rising edge of `sck_i` shifts `sdi_i` into the register's bit 0 and moves every other bit one place up. The first bit sent becomes bit WORD_W-1 of the word.
- R2: When `cs_ni` rises after exactly WORD_W rising edges, `word_valid_o` is high for exactly one system clock and `word_o` shows the captured word. `word_o` changes at no other time.
- R3: The rising edges of a frame may come in bursts with an idle serial clock between them, for example two bursts of 8 bits. The frame is still captured as long as `cs_ni` stays low throughout.
- R4: A frame with fewer or more than WORD_W rising edges produces no strobe and leaves `word_o` unchanged.
- R5: While `cs_ni` is high, serial-clock edges do not change the shift register or `sdo_o`.
- R6: With `edge_mode_i` = 1, `sdo_o` is updated at each selected rising edge to the register's top bit after that shift.
- R7: With `edge_mode_i` = 0, `sdo_o` keeps its value through the high phase and is updated at each selected falling edge to the register's current top bit.
- R8: When `sdo_o` of one instance drives `sdi_i` of a second instance on the same select and clock, the second instance captures, in either mode, the word the first instance captured one frame earlier.
- R9: While `rst_ni` is low, the shift register and `word_o` clear to zero, and `sdo_o` and `word_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| edge_mode_i | input | 1 | Output edge: 0 falling, 1 rising |
| sdo_o | output | 1 | Serial data out, top bit of the shift register |
| word_o | output | WORD_W | Last complete captured word |
| word_valid_o | output | 1 | One-cycle strobe when a complete word is captured |

## Verification
Two instances are chained output to input. Walking-one, walking-zero and dense words are sent in both output modes. Each word tells apart a bit-order or position error in the first instance from a lost or duplicated bit in the hand-off to the second. At every serial phase the output is sampled just before the next edge, which separates a rising-edge update from a falling-edge one. Split frames, frames of 15 and 17 bits, and clock toggling with the select high check the framing rules; a final reset checks the cleared state.

// File: rtl/spi_shf_pkg.sv
package spi_shf_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } sdo_edge_e;
endpackage

// File: rtl/spi_shf_sync.sv
module spi_shf_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[s-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/spi_shf_edge.sv
module spi_shf_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_LVL;
    else         prev_q <= level_i;

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/spi_shf_core.sv
module spi_shf_core
  import spi_shf_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  sdo_edge_e         edge_mode_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q, valid_q;
  logic [WORD_W-1:0] word_q;
  logic              shift_en, fall_en, complete;

  assign shift_en = sel_i & sck_rise_i;
  assign fall_en  = sel_i & sck_fall_i;
  assign shreg_d  = {shreg_q[WORD_W-2:0], sdi_i};
  assign complete = cs_rise_i && (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       shreg_q <= '0;
    else if (shift_en) shreg_q <= shreg_d;

  // saturate one past full so over-long frames stay invalid
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            cnt_q <= '0;
    else if (cs_fall_i)                     cnt_q <= '0;
    else if (shift_en && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sdo_q <= 1'b0;
    else if (edge_mode_i == EDGE_RISE) begin
      if (shift_en) sdo_q <= shreg_d[WORD_W-1];
    end else begin
      if (fall_en)  sdo_q <= shreg_q[WORD_W-1];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= complete;
      if (complete) word_q <= shreg_q;
    end

  assign sdo_o        = sdo_q;
  assign word_o       = word_q;
  assign word_valid_o = valid_q;
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_shf_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              edge_mode_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic cs_s, sck_s, sdi_s;
  logic sck_rise, sck_fall, cs_rise, cs_fall;

  spi_shf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   ({cs_s, sck_s, sdi_s})
  );

  spi_shf_edge #(.RST_LVL(1'b0)) u_sck_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(sck_s),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  spi_shf_edge #(.RST_LVL(1'b1)) u_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(cs_s),
    .rise_o(cs_rise), .fall_o(cs_fall)
  );

  spi_shf_core #(.WORD_W(WORD_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (~cs_s),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .sdi_i       (sdi_s),
    .cs_rise_i   (cs_rise),
    .cs_fall_i   (cs_fall),
    .edge_mode_i (sdo_edge_e'(edge_mode_i)),
    .sdo_o       (sdo_o),
    .word_o      (word_o),
    .word_valid_o(word_valid_o)
  );
endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              cs_rise,
  input logic              edge_mode_i,
  input logic              sdo_o,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);
  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  p_valid_after_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(cs_rise));

  p_word_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> word_valid_o);

  p_sdo_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdo_o) && $past(edge_mode_i)) |-> $past(sck_rise && !cs_s));

  p_sdo_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdo_o) && !$past(edge_mode_i)) |-> $past(sck_fall && !cs_s));
endmodule

bind spi_word_shifter spi_word_shifter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .sck_rise    (sck_rise),
  .sck_fall    (sck_fall),
  .cs_rise     (cs_rise),
  .edge_mode_i (edge_mode_i),
  .sdo_o       (sdo_o),
  .word_o      (word_o),
  .word_valid_o(word_valid_o)
);

// File: tb/spi_word_shifter_tb.sv
module spi_word_shifter_tb;
  localparam int W    = 16;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, din = 1'b0, mode = 1'b0;
  logic sdo_a, sdo_b, valid_a, valid_b;
  logic [W-1:0] word_a, word_b;

  int n_chk = 0, n_fail = 0;
  int cnt_a = 0, cnt_b = 0;
  logic [W-1:0] last_a = '0, last_b = '0;
  logic [W-1:0] m_a = '0, m_b = '0;

  always #2.5 clk = ~clk;

  spi_word_shifter #(.WORD_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(din),
    .edge_mode_i(mode), .sdo_o(sdo_a), .word_o(word_a), .word_valid_o(valid_a)
  );

  spi_word_shifter #(.WORD_W(W)) u_nxt (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdo_a),
    .edge_mode_i(mode), .sdo_o(sdo_b), .word_o(word_b), .word_valid_o(valid_b)
  );

  always @(negedge clk) begin
    if (valid_a) begin cnt_a++; last_a = word_a; end
    if (valid_b) begin cnt_b++; last_b = word_b; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send the low nbits of v, MSB first; check sdo_a at the end of every phase
  task automatic frame(input logic [31:0] v, input int nbits, input bit split);
    logic pre;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = v[nbits-1-i];
      tick(HALF);
      sck = 1'b1;
      pre = m_a[W-1];
      m_b = {m_b[W-2:0], pre};
      m_a = {m_a[W-2:0], din};
      tick(HALF-1);
      if (mode) chk("R6 sdo after rise", sdo_a, m_a[W-1]);
      else      chk("R7 sdo held in high phase", sdo_a, pre);
      tick(1);
      sck = 1'b0;
      tick(HALF-1);
      chk(mode ? "R6 sdo low phase" : "R7 sdo after fall", sdo_a, m_a[W-1]);
      tick(1);
      if (split && i == 7) tick(8*HALF);
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(2*HALF);
  endtask

  task automatic full_word(input logic [W-1:0] w, input bit split, input string tag);
    int ca, cb;
    logic [W-1:0] prev;
    ca = cnt_a; cb = cnt_b; prev = m_a;
    frame({16'h0, w}, W, split);
    chk({tag, " strobe count"}, cnt_a, ca + 1);
    chk({tag, " word"}, last_a, w);
    chk("R8 chained strobe", cnt_b, cb + 1);
    chk("R8 chained word", last_b, prev);
  endtask

  initial begin
    tick(3);
    chk("R9 reset sdo", sdo_a, 0);
    chk("R9 reset valid", valid_a, 0);
    chk("R9 reset word", word_a, 0);
    rst_n = 1'b1;
    tick(4);

    for (int md = 0; md < 2; md++) begin
      mode = md[0];
      tick(4);
      for (int b = 0; b < W; b++) full_word(W'(1) << b, 1'b0, "R1 walking one");
      for (int b = 0; b < W; b++) full_word(~(W'(1) << b), 1'b0, "R1 walking zero");
      full_word(16'hA5C3, 1'b0, "R1 dense");
      full_word(16'hFFFF, 1'b0, "R1 ones");
      full_word(16'h0000, 1'b0, "R1 zeros");
    end

    for (int md = 0; md < 2; md++) begin
      mode = md[0];
      full_word(16'h3C96 ^ 16'(md), 1'b1, "R3 split bursts");
    end

    begin
      logic s0;
      int ca;
      ca = cnt_a;
      s0 = sdo_a;
      for (int k = 0; k < 20; k++) begin
        din = k[0];
        tick(HALF); sck = 1'b1;
        tick(HALF); sck = 1'b0;
        chk("R5 sdo with select high", sdo_a, s0);
      end
      tick(2*HALF);
      chk("R5 no strobe with select high", cnt_a, ca);
      full_word(16'h1234, 1'b0, "R5 register kept");
    end

    for (int md = 0; md < 2; md++) begin
      logic [W-1:0] held;
      int ca;
      mode = md[0];
      held = word_a;
      ca = cnt_a;
      frame(32'h0000_5A5A, W-1, 1'b0);
      chk("R4 short frame strobe", cnt_a, ca);
      chk("R4 short frame word", word_a, held);
      frame(32'h0001_C3C3, W+1, 1'b0);
      chk("R4 long frame strobe", cnt_a, ca);
      chk("R4 long frame word", word_a, held);
      full_word(16'h0F0F ^ 16'(md), 1'b0, "R2 after bad frames");
    end

    rst_n = 1'b0;
    tick(3);
    chk("R9 reset again sdo", sdo_a, 0);
    chk("R9 reset again word", word_a, 0);
    chk("R9 reset again chained word", word_b, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL all watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule